// File: doc/BRIEF.md
# Buffered DAC Waveform Player

This block sits behind a 32-bit register port and feeds a four-channel digital-to-analog converter one 16-bit command word at a time. Each word leaving the block comes with a single-cycle strobe. A downstream serializer is expected to turn that word into the converter's own bus traffic. Inside the block there is a waveform buffer with one word per address. Software fills it by writing to the data register while playback is stopped, and each write advances a write pointer.

There are two ways to produce output. In manual mode, a data-register write is forwarded to the output straight away. In automatic mode, the block steps through the buffer at a programmable update period and returns to address 0 after it has played a programmable limit address. An interrupt pulse can mark each pass through the limit address. A status read returns the pointer that is active in the current mode. A reset bit in the command register clears both pointers and leaves the buffer contents as they are. After playback has been stopped, manual output stays blocked until such a reset is issued.

Top module: `dac_wave_player`

## Requirements
- R1: While automatic mode is off, each write to register 0 stores bits 15:0 in the buffer at the write pointer and then advances the pointer. The pointer wraps modulo the buffer depth (2^ADDR_W).
- R2: The 16-bit word carries the sample value in bits 11:0, an active-low load flag in bit 12, an active-low power-down flag in bit 13 and the channel number in bits 15:14. The block passes all 16 bits to `dac_word` unchanged and drops bus bits 31:16.
- R3: With command bit 7 (manual) set and automatic mode off, a write to register 0 drives its low 16 bits on `dac_word` with `dac_strobe` high in the cycle after the write edge.
- R4: With command bit 0 (automatic) set, one buffer word is output every update period. The period is US_CYCLES clocks when command bit 3 (divide) is clear, and 2·US_CYCLES·(D+1) clocks when it is set. D is the DIV_W-bit value held in register 2.
- R5: Playback starts at address 0 after a reset. After the word at the limit address (register 3, written) has been output, the next word comes from address 0.
- R6: Reading register 3 returns, in its low ADDR_W bits, the write pointer while automatic mode is off and the read pointer (the next address to play) while it is on. All other bits read 0.
- R7: With command bit 1 set, `irq` pulses for one cycle together with the strobe of the word taken from the limit address. With bit 1 clear, `irq` stays low.
- R8: A write to register 1 with bit 2 set clears both pointers and the update timer. It does not alter the buffer contents.
- R9: A write to register 0 while automatic mode is on has no effect. It does not change the buffer, does not move the write pointer and does not produce a strobe.
- R10: A command write that turns automatic mode off blocks manual output until a command write with bit 2 set follows. Buffer stores still take place while output is blocked.
- R11: After `rst_n` is released, `dac_strobe` and `irq` are low, `dac_word` is 0, the command reads 0 and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write enable, one cycle per write |
| bus_addr | input | 2 | Register select: 0 data, 1 command, 2 divider, 3 limit (write) / status (read) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| dac_word | output | 16 | Word presented to the converter serializer |
| dac_strobe | output | 1 | One-cycle qualifier for dac_word |
| irq | output | 1 | One-cycle pulse when the limit address is played |

## Verification
The bench writes more words than the buffer holds, to check that the write pointer wraps. Without that wrap, the status read would count past the depth and playback would show stale words at the low addresses. Playback runs across several passes of the limit. A design that wrapped one address early or late would put the wrong word after the limit word and misplace the interrupt pulse.

The divider values are swept, and the gap between strobes is measured in clocks. An off-by-one in the period formula shows up as a gap one step too long or too short. The bench also writes data during playback, issues a reset while playback runs, and switches to manual mode without a reset. A design that let any of these through would show a corrupted replay word, a pointer that does not return to zero, or a strobe where none is allowed.

// File: rtl/dac_wave_player.sv
module dac_wave_player #(
  parameter int ADDR_W    = 10,
  parameter int US_CYCLES = 50,
  parameter int DIV_W     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [15:0] dac_word,
  output logic        dac_strobe,
  output logic        irq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = DIV_W + $clog2(2 * US_CYCLES) + 1;

  logic [15:0]       wave_mem [DEPTH];
  logic              auto_q, irq_en_q, div_en_q, manual_q, lock_q;
  logic [DIV_W-1:0]  div_q;
  logic [ADDR_W-1:0] limit_q, wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt, period;
  logic              wr_data, wr_cmd, do_rst, tick;

  assign wr_data = bus_wr && bus_addr == 2'd0;
  assign wr_cmd  = bus_wr && bus_addr == 2'd1;
  assign do_rst  = wr_cmd && bus_wdata[2];
  assign period  = div_en_q ? CNT_W'(2 * US_CYCLES) * (CNT_W'(div_q) + CNT_W'(1))
                            : CNT_W'(US_CYCLES);
  assign tick    = auto_q && cnt >= period - CNT_W'(1);

  always_ff @(posedge clk)
    if (wr_data && !auto_q) wave_mem[wr_ptr] <= bus_wdata[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q <= 1'b0; irq_en_q <= 1'b0; div_en_q <= 1'b0; manual_q <= 1'b0;
      lock_q <= 1'b0; div_q <= '0; limit_q <= '0;
    end else begin
      if (wr_cmd) begin
        auto_q   <= bus_wdata[0];
        irq_en_q <= bus_wdata[1];
        div_en_q <= bus_wdata[3];
        manual_q <= bus_wdata[7];
        if (bus_wdata[2]) lock_q <= 1'b0;
        else if (auto_q && !bus_wdata[0]) lock_q <= 1'b1;
      end
      if (bus_wr && bus_addr == 2'd2) div_q <= bus_wdata[DIV_W-1:0];
      if (bus_wr && bus_addr == 2'd3) limit_q <= bus_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
    end else begin
      if (do_rst) wr_ptr <= '0;
      else if (wr_data && !auto_q) wr_ptr <= wr_ptr + 1'b1;
      if (do_rst) rd_ptr <= '0;
      else if (tick) rd_ptr <= (rd_ptr == limit_q) ? '0 : rd_ptr + 1'b1;
      if (!auto_q || do_rst || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_word <= '0; dac_strobe <= 1'b0; irq <= 1'b0;
    end else begin
      dac_strobe <= 1'b0;
      irq        <= 1'b0;
      if (tick) begin
        dac_word   <= wave_mem[rd_ptr];
        dac_strobe <= 1'b1;
        irq        <= irq_en_q && rd_ptr == limit_q;
      end else if (wr_data && manual_q && !auto_q && !lock_q) begin
        dac_word   <= bus_wdata[15:0];
        dac_strobe <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd1:    bus_rdata = {24'd0, manual_q, 3'd0, div_en_q, 1'b0, irq_en_q, auto_q};
      2'd2:    bus_rdata = 32'(div_q);
      2'd3:    bus_rdata = 32'(auto_q ? rd_ptr : wr_ptr);
      default: bus_rdata = '0;
    endcase
  end

  p_strobe_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(auto_q || manual_q));
  p_irq_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_ptr == '0);
  p_reset_ptrs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> (wr_ptr == '0 && rd_ptr == '0));
  p_auto_ignores_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && wr_data) |=> $stable(wr_ptr));
  p_locked_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !auto_q && wr_data) |=> !dac_strobe);
endmodule

// File: tb/dac_wave_player_test.sv
module dac_wave_player_test;
  localparam int AW = 4, US = 4, DW = 4, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] dac_word;
  logic dac_strobe, irq;
  int n_chk = 0, n_bad = 0;

  dac_wave_player #(.ADDR_W(AW), .US_CYCLES(US), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_word(dac_word),
    .dac_strobe(dac_strobe), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [15:0] dval(int i);
    return 16'(i * 16'h0731 + 16'h0100);
  endfunction
  function automatic logic [15:0] bufval(int a);
    return (a < 4) ? dval(a + 16) : dval(a);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask
  task automatic wait_strobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!dac_strobe && n < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int gap, a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 strobe", dac_strobe, 0);
    check("R11 irq", irq, 0);
    check("R11 word", dac_word, 0);
    rd(1, v); check("R11 command", v, 0);
    rd(3, v); check("R11 status", v, 0);

    for (int i = 0; i < 20; i++) begin
      wr(0, {16'hFFFF, dval(i)});
      check("R3 no strobe when manual off", dac_strobe, 0);
      rd(3, v); check("R1 write pointer", v, (i + 1) % DEPTH);
    end
    wr(1, 32'h4);
    rd(3, v); check("R8 reset clears write pointer", v, 0);

    wr(3, 5);
    wr(1, 32'h3);
    rd(1, v); check("R4 command readback", v, 32'h3);
    a = 0;
    for (int k = 0; k < 14; k++) begin
      wait_strobe(gap);
      check("R5 playback word", dac_word, bufval(a));
      check("R4 update period", gap, (k == 4) ? US - 1 : US);
      check("R7 irq at limit", irq, a == 5);
      a = (a == 5) ? 0 : a + 1;
      rd(3, v); check("R6 status shows read pointer", v, a);
      if (k == 3) wr(0, 32'hDEAD);
    end

    wr(1, 32'h5);
    rd(3, v); check("R8 reset clears read pointer", v, 0);
    wait_strobe(gap);
    check("R8 restart from 0 keeps contents", dac_word, bufval(0));
    check("R9 ignored write left buffer", dac_word, dval(16));

    for (int d = 0; d < 4; d++) begin
      wr(2, d);
      wr(1, 32'h9);
      wait_strobe(gap);
      wait_strobe(gap);
      check("R4 divided period", gap, 2 * US * (d + 1));
      check("R7 irq off", irq, 0);
    end
    wr(2, 3);
    wr(1, 32'h1);
    wait_strobe(gap);
    wait_strobe(gap);
    check("R4 divider ignored when divide off", gap, US);

    wr(1, 32'h80);
    rd(3, v); check("R9 write pointer unmoved", v, 0);
    wr(0, 32'h1234);
    check("R10 manual blocked before reset", dac_strobe, 0);
    rd(3, v); check("R10 store still advances", v, 1);
    wr(1, 32'h84);
    wr(0, 32'hFFFF_5A3C);
    check("R3 manual strobe", dac_strobe, 1);
    check("R2 upper bits dropped", dac_word, 16'h5A3C);
    for (int ch = 0; ch < 4; ch++)
      for (int pd = 0; pd < 2; pd++)
        for (int ld = 0; ld < 2; ld++) begin
          logic [15:0] w;
          w = {2'(ch), 1'(pd), 1'(ld), 12'(ch * 12'h351 + pd * 12'h0F0 + ld)};
          wr(0, {16'h0, w});
          check("R2 field layout", {dac_word[15:14], dac_word[13], dac_word[12], dac_word[11:0]}, w);
          check("R3 strobe per write", dac_strobe, 1);
        end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule